// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic unit of a small microcoded datapath. It holds an accumulator register that captures the shared bus value when told to, combines the accumulator with the present bus value according to a 3-bit operation code, and stores the outcome in a separate result register. Each time the result register is written, three condition flags are refreshed: a zero flag, a sign flag and a carry flag. A microcode sequencer elsewhere reads these flags to make conditional jumps.

The accumulator is always the first operand. A typical microcode step first loads the accumulator from the bus, then places the second operand on the bus and writes the result register with the chosen operation. Both registers have independent write enables. When both enables are high on the same edge, the operation uses the accumulator value from before that edge. The asynchronous active-low reset is released to the registers through a two-stage synchronizer.

Top module: `acc_alu`

## Requirements
- R1: While reset is applied, the accumulator, the result register and all three flags are 0. Once the two-cycle reset release is complete, the first operation sees an accumulator of 0.
- R2: The accumulator captures `bus_in` on a clock edge only when `acc_we` is 1. Otherwise it keeps its value.
- R3: The result register and the flags change only on an edge where `res_we` is 1. That edge uses the accumulator value from before the edge, even if `acc_we` is also 1.
- R4: Code 000 (add) stores A + bus modulo 2^32. Carry is the carry out of bit 31.
- R5: Code 001 (subtract) stores A - bus modulo 2^32. Carry is 1 exactly when A < bus as unsigned numbers (borrow).
- R6: Codes 010 (AND) and 011 (OR) store the bitwise AND or the bitwise OR of A and bus. Carry is 0 for both.
- R7: Code 100 stores the bitwise inverse of A and ignores the bus. Carry is 0.
- R8: Code 101 (pass) stores the bus value unchanged. Carry is 0.
- R9: Code 110 stores A shifted right by one place with a 0 entering bit 31. Carry takes the old A bit 0.
- R10: Code 111 stores A shifted left by one place with a 0 entering bit 0. Carry takes the old A bit 31.
- R11: On every result write, zero is 1 exactly when the stored 32-bit result is 0, and sign equals bit 31 of the stored result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 32 | Shared bus value (second operand and accumulator load data) |
| alu_op | input | 3 | Operation code |
| acc_we | input | 1 | Accumulator write enable |
| res_we | input | 1 | Result register and flag write enable |
| res_out | output | 32 | Result register G |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_cy | output | 1 | Carry / borrow / shifted-out flag |

## Verification
An operation presented with `res_we` appears on `res_out` and the flags one clock edge later. An accumulator load appears only in the operations issued on later edges. The bench changes the inputs on falling edges and compares every output at the next falling edge against a reference model. The model advances once per rising edge and uses the accumulator value from before that edge, so same-edge loads and operations are judged exactly in the cycle their result becomes due. The bench also waits out the two reset-release cycles before it drives any operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_NOTA = 3'b100,
    OP_PASS = 3'b101,
    OP_SHR  = 3'b110,
    OP_SHL  = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic s;
    logic cy;
  } alu_flags_t;

endpackage

// File: rtl/acc_alu_rstsync.sv
module acc_alu_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_alu_accreg.sv
module acc_alu_accreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] acc_q
);

  logic [W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (load_en) begin
      acc_d = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/acc_alu_opunit.sv
module acc_alu_opunit
  import acc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result,
  output logic         carry
);

  localparam int MSB = W - 1;

  logic         is_sub;
  logic [W-1:0] addend;
  logic [W:0]   sum_ext;

  // One adder serves both add and subtract: subtract adds the inverted
  // operand plus one, and its carry out is the inverse of the borrow.
  always_comb begin
    is_sub  = (op == OP_SUB);
    addend  = is_sub ? ~opb : opb;
    sum_ext = {1'b0, opa} + {1'b0, addend} + {{W{1'b0}}, is_sub};
  end

  always_comb begin
    result = '0;
    carry  = 1'b0;
    unique case (op)
      OP_ADD: begin
        result = sum_ext[MSB:0];
        carry  = sum_ext[W];
      end
      OP_SUB: begin
        result = sum_ext[MSB:0];
        carry  = ~sum_ext[W];
      end
      OP_AND:  result = opa & opb;
      OP_OR:   result = opa | opb;
      OP_NOTA: result = ~opa;
      OP_PASS: result = opb;
      OP_SHR: begin
        result = {1'b0, opa[MSB:1]};
        carry  = opa[0];
      end
      OP_SHL: begin
        result = {opa[MSB-1:0], 1'b0};
        carry  = opa[MSB];
      end
      default: begin
        result = '0;
        carry  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu_resreg.sv
module acc_alu_resreg
  import acc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] res_nxt,
  input  logic         cy_nxt,
  output logic [W-1:0] res_q,
  output alu_flags_t   flags_q
);

  logic [W-1:0] res_d;
  alu_flags_t   flags_d;
  alu_flags_t   flags_new;

  always_comb begin
    flags_new.z  = ~|res_nxt;
    flags_new.s  = res_nxt[W-1];
    flags_new.cy = cy_nxt;
  end

  always_comb begin
    res_d   = res_q;
    flags_d = flags_q;
    if (wr_en) begin
      res_d   = res_nxt;
      flags_d = flags_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      res_q   <= res_d;
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_in,
  input  logic [2:0]   alu_op,
  input  logic         acc_we,
  input  logic         res_we,
  output logic [W-1:0] res_out,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_cy
);

  logic         rst_sync_n;
  logic [W-1:0] acc_val;
  logic [W-1:0] op_result;
  logic         op_carry;
  alu_flags_t   flags;
  alu_op_e      op_sel;

  assign op_sel = alu_op_e'(alu_op);

  acc_alu_rstsync #(.STAGES(SYNC_STAGES)) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acc_alu_accreg #(.W(W)) u_accreg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (acc_we),
    .load_val (bus_in),
    .acc_q    (acc_val)
  );

  acc_alu_opunit #(.W(W)) u_opunit (
    .op     (op_sel),
    .opa    (acc_val),
    .opb    (bus_in),
    .result (op_result),
    .carry  (op_carry)
  );

  acc_alu_resreg #(.W(W)) u_resreg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (res_we),
    .res_nxt (op_result),
    .cy_nxt  (op_carry),
    .res_q   (res_out),
    .flags_q (flags)
  );

  assign flag_z  = flags.z;
  assign flag_s  = flags.s;
  assign flag_cy = flags.cy;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] bus_in,
  input logic [2:0]   alu_op,
  input logic         res_we,
  input logic [W-1:0] res_out,
  input logic         flag_z,
  input logic         flag_s,
  input logic         flag_cy
);

  // R3: without a result write, the result and the flags hold
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_we |=> ($stable(res_out) && $stable({flag_z, flag_s, flag_cy})));

  // R11: the zero flag matches the stored result
  a_r11_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> (flag_z == (res_out == '0)));

  // R11: the sign flag matches the top bit of the stored result
  a_r11_sign: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> (flag_s == res_out[W-1]));

  // R8: pass stores the bus value and clears carry
  a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && alu_op == 3'b101) |=> (res_out == $past(bus_in) && !flag_cy));

  // R6 and R7: logic operations clear carry
  a_r6_logic_cy: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && (alu_op == 3'b010 || alu_op == 3'b011 || alu_op == 3'b100))
      |=> !flag_cy);

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .bus_in  (bus_in),
  .alu_op  (alu_op),
  .res_we  (res_we),
  .res_out (res_out),
  .flag_z  (flag_z),
  .flag_s  (flag_s),
  .flag_cy (flag_cy)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] bus_in;
  logic [2:0]  alu_op;
  logic        acc_we;
  logic        res_we;
  logic [31:0] res_out;
  logic        flag_z;
  logic        flag_s;
  logic        flag_cy;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state
  logic [31:0] m_a, m_g;
  logic        m_z, m_s, m_cy;

  acc_alu u_acc_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_in  (bus_in),
    .alu_op  (alu_op),
    .acc_we  (acc_we),
    .res_we  (res_we),
    .res_out (res_out),
    .flag_z  (flag_z),
    .flag_s  (flag_s),
    .flag_cy (flag_cy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic compare(input string tag);
    checks++;
    if (res_out !== m_g || flag_z !== m_z || flag_s !== m_s || flag_cy !== m_cy) begin
      errors++;
      $display("FAIL %s: actual G=%h z=%b s=%b cy=%b expected G=%h z=%b s=%b cy=%b",
               tag, res_out, flag_z, flag_s, flag_cy, m_g, m_z, m_s, m_cy);
    end
  endtask

  task automatic model_edge(input logic [31:0] b, input logic [2:0] op,
                            input logic awe, input logic gwe);
    logic [31:0] r;
    logic        c;
    longint      wide;
    r = '0;
    c = 1'b0;
    case (op)
      3'd0: begin
        wide = longint'(m_a) + longint'(b);
        r = wide[31:0];
        c = wide[32];
      end
      3'd1: begin r = m_a - b; c = (m_a < b); end
      3'd2: r = m_a & b;
      3'd3: r = m_a | b;
      3'd4: r = ~m_a;
      3'd5: r = b;
      3'd6: begin r = m_a / 2; c = m_a[0]; end
      default: begin r = m_a * 2; c = m_a[31]; end
    endcase
    if (gwe) begin
      m_g  = r;
      m_z  = (r == 0);
      m_s  = r[31];
      m_cy = c;
    end
    if (awe) m_a = b;
  endtask

  // drive at a falling edge, let one rising edge pass, check at the next falling edge
  task automatic step(input logic [31:0] b, input logic [2:0] op,
                      input logic awe, input logic gwe, input string tag);
    bus_in = b;
    alu_op = op;
    acc_we = awe;
    res_we = gwe;
    @(posedge clk);
    model_edge(b, op, awe, gwe);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic load_a(input logic [31:0] v, input string tag);
    step(v, 3'd5, 1'b1, 1'b0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    rst_n  = 1'b0;
    bus_in = 32'h1234_5678;
    alu_op = 3'd0;
    acc_we = 1'b1;
    res_we = 1'b1;
    m_a = '0; m_g = '0; m_z = 1'b0; m_s = 1'b0; m_cy = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rst_n  = 1'b1;
    acc_we = 1'b0;
    res_we = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 after release");

    // R1: accumulator is 0 after reset, so NOT A gives all ones
    step(32'hDEAD_BEEF, 3'd4, 1'b0, 1'b1, "R1 A cleared");
    // R2: no load without acc_we
    step(32'h0000_00FF, 3'd4, 1'b0, 1'b1, "R2 A holds");
    load_a(32'h0000_0005, "R2 load no result change");
    step(32'h0, 3'd4, 1'b0, 1'b1, "R2 A loaded");
    // R3: result holds without res_we
    step(32'hFFFF_FFFF, 3'd0, 1'b0, 1'b0, "R3 hold");
    // R3: same-edge load and operation uses old A
    step(32'h0000_0100, 3'd0, 1'b1, 1'b1, "R3 same edge old A");
    step(32'h0000_0001, 3'd0, 1'b0, 1'b1, "R3 new A next op");
    // R4: add with carry out and zero
    load_a(32'hFFFF_FFFF, "R4 load");
    step(32'h0000_0001, 3'd0, 1'b0, 1'b1, "R4 add carry zero");
    step(32'h7FFF_FFFF, 3'd0, 1'b0, 1'b1, "R4 add carry");
    // R5: subtract borrow cases
    load_a(32'h0000_0003, "R5 load");
    step(32'h0000_0005, 3'd1, 1'b0, 1'b1, "R5 borrow");
    step(32'h0000_0003, 3'd1, 1'b0, 1'b1, "R5 equal zero");
    step(32'h0000_0001, 3'd1, 1'b0, 1'b1, "R5 no borrow");
    // R6: AND / OR clear carry (carry set first)
    load_a(32'h8000_0001, "R6 load");
    step(32'h0, 3'd6, 1'b0, 1'b1, "R9 shr carry out");
    step(32'h0F0F_0F0F, 3'd2, 1'b0, 1'b1, "R6 and");
    step(32'h0, 3'd7, 1'b0, 1'b1, "R10 shl carry out");
    step(32'h0F0F_0F0E, 3'd3, 1'b0, 1'b1, "R6 or");
    // R7: NOT ignores bus
    step(32'h1111_1111, 3'd4, 1'b0, 1'b1, "R7 not a");
    // R8: pass
    step(32'h8000_0000, 3'd5, 1'b0, 1'b1, "R8 pass negative");
    step(32'h0, 3'd5, 1'b0, 1'b1, "R8 pass zero");
    // R9 / R10: shifts fill with zero
    load_a(32'hFFFF_FFFE, "R9 load");
    step(32'h0, 3'd6, 1'b0, 1'b1, "R9 shr fill");
    step(32'h0, 3'd7, 1'b0, 1'b1, "R10 shl fill");
    load_a(32'h0000_0001, "R11 load");
    step(32'h0, 3'd6, 1'b0, 1'b1, "R11 shr to zero");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      step($urandom, 3'($urandom), 1'($urandom), 1'($urandom), "R11 mixed");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule